// File: doc/BRIEF.md
# DSP to Strobe-Acknowledge Bus Bridge

This block sits between a signal processor whose external bus is clocked and extended by a ready line, and a peripheral bus controller that expects an address strobe, a data strobe and an asynchronous acknowledge. A processor cycle starts when `dspStrobe` is high. The bridge captures the word address, the write data and the direction, and wins the local bus through a request, grant and grant-acknowledge exchange. It then drives the two strobes and holds `dspReady` low until the controller acknowledges. Every transfer is a long-word transfer. The byte address is the word address shifted left by two, and the size code is always zero.

The acknowledge pair `portAck[1:0]` and the grant input are asynchronous, so each passes through a two-stage synchronizer before use. The value `2'b11` on the acknowledge pair means a 32-bit port. Any other non-zero code still ends the cycle, but it raises a size-error flag. If no acknowledge is seen within a parameterized number of clocks, the cycle ends with a bus-error flag. A read issued with `dspLock` high leaves the address strobe and the grant acknowledge asserted, so that the following write completes an indivisible read-modify-write pair. All signals are active high.

Top module: `dsp_async_bridge`

## Requirements
- R1: While reset is applied and right after it, addrStrobe, dataStrobe, dspReady, busReq and busGrantAck are all low.
- R2: An unlocked cycle raises busReq. The synchronized grant moves the bridge to the address phase, so addrStrobe rises 3 clocks after busReq rises when the grant is driven as soon as busReq is seen. busGrantAck is high whenever addrStrobe rises, and busReq is low whenever busGrantAck is high.
- R3: dataStrobe rises exactly one clock after addrStrobe rises. In a cycle that is not a locked read, both strobes fall in the same clock.
- R4: During a transfer, busAddr equals {dspAddr[21:0], 2'b00}, busSize is 2'b00, and busWrite follows the captured direction (1 = write). On writes, busDataOe is high and busWdata carries the captured dspWdata.
- R5: With portAck = 2'b11, dspReady is high 3 clocks after the acknowledge changes. A read returns busRdata on dspRdata, and dspBusErr and dspSizeErr are both low.
- R6: An acknowledge code of 2'b01 or 2'b10 still completes the cycle, with dspSizeErr = 1 and dspBusErr = 0. Read data is still captured.
- R7: If no acknowledge is seen, dspReady rises TIMEOUT_CYCLES clocks after dataStrobe rises (256 by default), with dspBusErr = 1 and dspSizeErr = 0.
- R8: An acknowledge whose synchronized value first appears in the same clock as the timeout wins: the cycle ends with dspBusErr = 0. An acknowledge one clock later loses, and dspBusErr = 1.
- R9: A new cycle does not assert addrStrobe until portAck has been released. With a pending strobe, addrStrobe rises 7 clocks after the release.
- R10: A read with dspLock high keeps addrStrobe and busGrantAck asserted after its dspReady pulse. The following write runs with no new busReq and no new rising edge of addrStrobe.
- R11: If dspLock falls while a locked read is being held and no strobe is pending, addrStrobe and busGrantAck go low.
- R12: dspReady is a single-clock pulse, given once per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dspStrobe | input | 1 | Processor cycle strobe |
| dspWrite | input | 1 | Direction, 1 = write |
| dspLock | input | 1 | Lock for read-modify-write pairs |
| dspAddr | input | 24 | Word address |
| dspWdata | input | 32 | Write data |
| dspRdata | output | 32 | Read data, valid with dspReady |
| dspReady | output | 1 | Cycle completion pulse |
| dspBusErr | output | 1 | Timeout flag, valid with dspReady |
| dspSizeErr | output | 1 | Non-32-bit acknowledge flag, valid with dspReady |
| busReq | output | 1 | Bus request |
| busGrant | input | 1 | Bus grant, asynchronous |
| busGrantAck | output | 1 | Grant acknowledge, bus owned |
| addrStrobe | output | 1 | Address strobe |
| dataStrobe | output | 1 | Data strobe |
| busWrite | output | 1 | Bus direction, 1 = write |
| busSize | output | 2 | Transfer size code, always 00 |
| busAddr | output | 24 | Byte address |
| busWdata | output | 32 | Write data toward controller |
| busDataOe | output | 1 | Write data drive enable |
| busRdata | input | 32 | Read data from controller |
| portAck | input | 2 | Asynchronous acknowledge pair |

## Verification
The timeout counter and the synchronized acknowledge can both complete the data phase in the same clock. The bench provokes this by placing the acknowledge edge so that its synchronized copy arrives in exactly the last counted clock, and then one clock later. The per-clock model predicts the ready clock from the acknowledge drive time and from the first data-strobe clock, and it expects a clean finish in the first case and a bus error in the second. A second overlap is a new processor strobe that arrives while the previous acknowledge is still held. It is judged by the clock at which the address strobe rises after the release.

// File: rtl/dab_pkg.sv
package dab_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_DONE,
    ST_RECOVER
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic runTimer;
    logic finishAck;
    logic finishTimeout;
  } dpCtl_t;

  localparam logic [1:0] ACK_NONE  = 2'b00;
  localparam logic [1:0] ACK_LONG  = 2'b11;
  localparam logic [1:0] SIZE_LONG = 2'b00;

endpackage

// File: rtl/dab_sync.sv
module dab_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/dab_ctrl.sv
module dab_ctrl
  import dab_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dspStrobe,
  input  logic       dspLock,
  input  logic [1:0] ackSync,
  input  logic       grantSync,
  input  logic       timeoutHit,
  input  logic       heldWrite,
  input  logic       heldLock,
  output dpCtl_t     ctl,
  output logic       busReq,
  output logic       grantAck,
  output logic       addrStrobe,
  output logic       dataStrobe,
  output logic       dataDrive,
  output logic       dspReady
);

  busState_e state, nextState;
  logic      lockHold, nextLockHold;
  logic      ackSeen;

  assign ackSeen = (ackSync != ACK_NONE);

  always_comb begin
    nextState    = state;
    nextLockHold = lockHold;
    ctl          = '0;
    unique case (state)
      ST_IDLE: begin
        if (dspStrobe) begin
          ctl.capture = 1'b1;
          // a held locked read already owns the bus and the address strobe
          nextState   = lockHold ? ST_ADDR : ST_REQ;
        end else if (lockHold && !dspLock) begin
          nextLockHold = 1'b0;
        end
      end
      ST_REQ: begin
        if (grantSync) nextState = ST_ADDR;
      end
      ST_ADDR: begin
        nextState = ST_DATA;
      end
      ST_DATA: begin
        ctl.runTimer = 1'b1;
        if (ackSeen) begin
          // acknowledge has priority over a timeout in the same clock
          ctl.finishAck = 1'b1;
          nextState     = ST_DONE;
          nextLockHold  = heldLock && !heldWrite;
        end else if (timeoutHit) begin
          ctl.finishTimeout = 1'b1;
          nextState         = ST_DONE;
          nextLockHold      = heldLock && !heldWrite;
        end
      end
      ST_DONE: begin
        nextState = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (!ackSeen) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lockHold <= 1'b0;
    end else begin
      state    <= nextState;
      lockHold <= nextLockHold;
    end
  end

  assign busReq     = (state == ST_REQ);
  assign grantAck   = lockHold || (state inside {ST_ADDR, ST_DATA, ST_DONE, ST_RECOVER});
  assign addrStrobe = lockHold || (state inside {ST_ADDR, ST_DATA});
  assign dataStrobe = (state == ST_DATA);
  assign dataDrive  = heldWrite && (state inside {ST_ADDR, ST_DATA});
  assign dspReady   = (state == ST_DONE);

endmodule

// File: rtl/dab_dpath.sv
module dab_dpath
  import dab_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] dspAddr,
  input  logic [DATA_W-1:0] dspWdata,
  input  logic              dspWrite,
  input  logic              dspLock,
  input  logic [1:0]        ackSync,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              heldWrite,
  output logic              heldLock,
  output logic [DATA_W-1:0] dspRdata,
  output logic              busErr,
  output logic              sizeErr,
  output logic              timeoutHit
);

  localparam int BYTE_SHIFT = $clog2(DATA_W / 8);
  localparam int CNT_W      = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [ADDR_W-1:0] wordAddr;
  logic [DATA_W-1:0] wdataQ;
  logic [CNT_W-1:0]  waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr  <= '0;
      wdataQ    <= '0;
      heldWrite <= 1'b0;
      heldLock  <= 1'b0;
    end else if (ctl.capture) begin
      wordAddr  <= dspAddr;
      wdataQ    <= dspWdata;
      heldWrite <= dspWrite;
      heldLock  <= dspLock;
    end
  end

  assign busAddr  = {wordAddr[ADDR_W-BYTE_SHIFT-1:0], {BYTE_SHIFT{1'b0}}};
  assign busWdata = wdataQ;

  // counter is zero outside the data phase, so the compare needs no qualifier
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   waitCnt <= '0;
    else if (!ctl.runTimer)      waitCnt <= '0;
    else if (waitCnt != LAST_COUNT) waitCnt <= waitCnt + CNT_W'(1);
  end

  assign timeoutHit = (waitCnt == LAST_COUNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dspRdata <= '0;
      busErr   <= 1'b0;
      sizeErr  <= 1'b0;
    end else if (ctl.finishAck) begin
      if (!heldWrite) dspRdata <= busRdata;
      busErr  <= 1'b0;
      sizeErr <= (ackSync != ACK_LONG);
    end else if (ctl.finishTimeout) begin
      dspRdata <= '0;
      busErr   <= 1'b1;
      sizeErr  <= 1'b0;
    end
  end

endmodule

// File: rtl/dsp_async_bridge.sv
module dsp_async_bridge
  import dab_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 256,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dspStrobe,
  input  logic              dspWrite,
  input  logic              dspLock,
  input  logic [ADDR_W-1:0] dspAddr,
  input  logic [DATA_W-1:0] dspWdata,
  output logic [DATA_W-1:0] dspRdata,
  output logic              dspReady,
  output logic              dspBusErr,
  output logic              dspSizeErr,
  output logic              busReq,
  input  logic              busGrant,
  output logic              busGrantAck,
  output logic              addrStrobe,
  output logic              dataStrobe,
  output logic              busWrite,
  output logic [1:0]        busSize,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busRdata,
  input  logic [1:0]        portAck
);

  dpCtl_t     ctl;
  logic [1:0] ackSync;
  logic       grantSync;
  logic       timeoutHit;
  logic       heldWrite;
  logic       heldLock;

  dab_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) ackSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(portAck), .syncOut(ackSync)
  );

  dab_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) grantSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(busGrant), .syncOut(grantSync)
  );

  dab_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .dspStrobe(dspStrobe), .dspLock(dspLock),
    .ackSync(ackSync), .grantSync(grantSync), .timeoutHit(timeoutHit),
    .heldWrite(heldWrite), .heldLock(heldLock), .ctl(ctl),
    .busReq(busReq), .grantAck(busGrantAck), .addrStrobe(addrStrobe),
    .dataStrobe(dataStrobe), .dataDrive(busDataOe), .dspReady(dspReady)
  );

  dab_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dspAddr(dspAddr), .dspWdata(dspWdata),
    .dspWrite(dspWrite), .dspLock(dspLock), .ackSync(ackSync), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .heldWrite(heldWrite), .heldLock(heldLock),
    .dspRdata(dspRdata), .busErr(dspBusErr), .sizeErr(dspSizeErr), .timeoutHit(timeoutHit)
  );

  assign busWrite = heldWrite;
  assign busSize  = SIZE_LONG;

endmodule

// File: rtl/dab_checker.sv
module dab_checker (
  input logic       clk,
  input logic       rstN,
  input logic       addrStrobe,
  input logic       dataStrobe,
  input logic       busReq,
  input logic       busGrantAck,
  input logic       dspReady,
  input logic [1:0] ackSync
);

  // R3
  ds_needs_as_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataStrobe |-> addrStrobe);

  // R3
  ds_after_as_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataStrobe) |-> $past(addrStrobe));

  // R2
  req_off_when_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    busGrantAck |-> !busReq);

  // R2
  as_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrStrobe) |-> busGrantAck);

  // R12
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dspReady |=> !dspReady);

  // R9
  ack_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrStrobe) |-> ($past(ackSync) == 2'b00));

endmodule

bind dsp_async_bridge dab_checker chk_i (
  .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .dataStrobe(dataStrobe),
  .busReq(busReq), .busGrantAck(busGrantAck), .dspReady(dspReady), .ackSync(ackSync)
);

// File: tb/dsp_async_bridge_tb_top.sv
`timescale 1ns/1ps
module dsp_async_bridge_tb_top;

  localparam int LIMIT = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dspStrobe = 1'b0, dspWrite = 1'b0, dspLock = 1'b0;
  logic [23:0] dspAddr = '0;
  logic [31:0] dspWdata = '0;
  logic [31:0] dspRdata;
  logic        dspReady, dspBusErr, dspSizeErr;
  logic        busReq, busGrantAck, addrStrobe, dataStrobe, busWrite, busDataOe;
  logic        busGrant = 1'b0;
  logic [1:0]  busSize;
  logic [23:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic [1:0]  portAck = 2'b00;

  dsp_async_bridge dut_i (
    .clk(clk), .rstN(rstN), .dspStrobe(dspStrobe), .dspWrite(dspWrite), .dspLock(dspLock),
    .dspAddr(dspAddr), .dspWdata(dspWdata), .dspRdata(dspRdata), .dspReady(dspReady),
    .dspBusErr(dspBusErr), .dspSizeErr(dspSizeErr), .busReq(busReq), .busGrant(busGrant),
    .busGrantAck(busGrantAck), .addrStrobe(addrStrobe), .dataStrobe(dataStrobe),
    .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .busDataOe(busDataOe), .busRdata(busRdata), .portAck(portAck)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, tick = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000", tick);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // controller model: acknowledge responder
  logic [1:0]  respCode = 2'b11;
  int          respDelay = 0, respRelease = 0;
  logic [31:0] respData = '0;
  bit          dsActive = 0, acked = 0, releasing = 0;
  int          relCnt = 0, tDs = 0, tAck = 0;
  logic [23:0] seenAddr; logic [31:0] seenWdata; logic seenWrite, seenOe; logic [1:0] seenSize;

  always @(negedge clk) begin
    if (dataStrobe && !dsActive) begin dsActive = 1; tDs = tick; acked = 0; end
    if (dsActive && !acked && respDelay >= 0 && tick == tDs + respDelay) begin
      portAck = respCode; busRdata = respData; acked = 1; tAck = tick;
      seenAddr = busAddr; seenWdata = busWdata; seenWrite = busWrite;
      seenOe = busDataOe; seenSize = busSize;
    end
    if (!dataStrobe && dsActive) begin dsActive = 0; relCnt = respRelease; releasing = 1; end
    if (releasing) begin
      if (relCnt == 0) begin portAck = 2'b00; releasing = 0; end
      else relCnt--;
    end
  end

  // arbiter model
  always @(negedge clk) begin
    if (busGrantAck) busGrant = 1'b0;
    else if (busReq) busGrant = 1'b1;
  end

  // per-clock protocol monitor
  bit prevAs = 0, prevDs = 0, prevReq = 0, prevGa = 0, lockReadCur = 0;
  int asRises = 0, reqRises = 0, readyTicks = 0, tAsRise = 0, tReqRise = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (addrStrobe && !prevAs) begin asRises++; tAsRise = tick; end
      if (busReq && !prevReq) begin reqRises++; tReqRise = tick; end
      if (dspReady) readyTicks++;
      if (dataStrobe && !prevDs) chk(prevAs && addrStrobe, "R3", "as before ds", prevAs, 1);
      if (!dataStrobe && prevDs && !lockReadCur) chk(!addrStrobe, "R3", "strobes fall together", addrStrobe, 0);
      if (busGrantAck && !prevGa) chk(!busReq, "R2", "req off at grant ack", busReq, 0);
    end
    prevAs = addrStrobe; prevDs = dataStrobe; prevReq = busReq; prevGa = busGrantAck;
  end

  logic [31:0] gotRdata; logic gotBe, gotSe; int tRdy;

  task automatic doCycle(input logic wr, input logic lk, input logic [23:0] a,
                         input logic [31:0] wd, input logic [1:0] code, input int dly,
                         input logic [31:0] rd, input int relHold);
    int readyBase;
    respCode = code; respDelay = dly; respData = rd; respRelease = relHold;
    @(negedge clk);
    lockReadCur = lk && !wr;
    readyBase = readyTicks;
    dspStrobe = 1'b1; dspWrite = wr; dspLock = lk; dspAddr = a; dspWdata = wd;
    do @(negedge clk); while (!dspReady);
    gotRdata = dspRdata; gotBe = dspBusErr; gotSe = dspSizeErr; tRdy = tick;
    dspStrobe = 1'b0;
    if (!(lk && !wr)) dspLock = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(readyTicks - readyBase == 1, "R12", "ready pulses", readyTicks - readyBase, 1);
  endtask

  initial begin
    int reqBase, asBase, tPrev;
    repeat (3) @(negedge clk);
    // R1
    chk({addrStrobe, dataStrobe, dspReady, busReq, busGrantAck} == 5'b0, "R1", "outputs in reset",
        {addrStrobe, dataStrobe, dspReady, busReq, busGrantAck}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({addrStrobe, dataStrobe, dspReady, busReq, busGrantAck} == 5'b0, "R1", "outputs after reset",
        {addrStrobe, dataStrobe, dspReady, busReq, busGrantAck}, 0);

    // basic read, R5, R2, R3, R4
    doCycle(1'b0, 1'b0, 24'h123456, 32'h0, 2'b11, 2, 32'hCAFEF00D, 0);
    chk(gotRdata == 32'hCAFEF00D, "R5", "read data", gotRdata, 32'hCAFEF00D);
    chk(!gotBe && !gotSe, "R5", "flags clean", {gotBe, gotSe}, 0);
    chk(tRdy == tAck + 3, "R5", "ready latency", tRdy - tAck, 3);
    chk(tAsRise - tReqRise == 3, "R2", "req to as", tAsRise - tReqRise, 3);
    chk(tDs - tAsRise == 1, "R3", "as to ds", tDs - tAsRise, 1);
    chk(seenAddr == {24'h123456 & 24'h3FFFFF, 2'b00} >> 0 ? 1'b1 : 1'b0, "R4", "byte address",
        seenAddr, 24'h48D158);
    chk(seenSize == 2'b00 && !seenWrite && !seenOe, "R4", "read size/dir",
        {seenSize, seenWrite, seenOe}, 0);

    // write, R4 R5
    doCycle(1'b1, 1'b0, 24'hFFFFFF, 32'h5A5A0FF0, 2'b11, 0, 32'h0, 0);
    chk(seenWdata == 32'h5A5A0FF0, "R4", "write data", seenWdata, 32'h5A5A0FF0);
    chk(seenWrite && seenOe, "R4", "write dir/oe", {seenWrite, seenOe}, 2'b11);
    chk(seenAddr == 24'hFFFFFC, "R4", "write address", seenAddr, 24'hFFFFFC);
    chk(tRdy == tDs + 3, "R5", "ready latency d0", tRdy - tDs, 3);

    // odd acknowledge codes, R6
    doCycle(1'b0, 1'b0, 24'h000010, 32'h0, 2'b01, 1, 32'h13579BDF, 0);
    chk(gotSe && !gotBe, "R6", "code 01 flags", {gotSe, gotBe}, 2'b10);
    chk(gotRdata == 32'h13579BDF, "R6", "code 01 data", gotRdata, 32'h13579BDF);
    doCycle(1'b1, 1'b0, 24'h000020, 32'h1, 2'b10, 3, 32'h0, 0);
    chk(gotSe && !gotBe, "R6", "code 10 flags", {gotSe, gotBe}, 2'b10);

    // timeout, R7
    doCycle(1'b0, 1'b0, 24'h000030, 32'h0, 2'b11, -1, 32'h0, 0);
    chk(gotBe && !gotSe, "R7", "timeout flags", {gotBe, gotSe}, 2'b10);
    chk(tRdy == tDs + LIMIT, "R7", "timeout clock", tRdy - tDs, LIMIT);

    // same-clock race, R8
    doCycle(1'b0, 1'b0, 24'h000040, 32'h0, 2'b11, LIMIT - 3, 32'hA1B2C3D4, 0);
    chk(!gotBe, "R8", "ack wins tie", gotBe, 0);
    chk(gotRdata == 32'hA1B2C3D4, "R8", "tie data", gotRdata, 32'hA1B2C3D4);
    chk(tRdy == tDs + LIMIT, "R8", "tie clock", tRdy - tDs, LIMIT);
    doCycle(1'b0, 1'b0, 24'h000044, 32'h0, 2'b11, LIMIT - 2, 32'h0, 0);
    chk(gotBe, "R8", "late ack loses", gotBe, 1);
    chk(tRdy == tDs + LIMIT, "R8", "late clock", tRdy - tDs, LIMIT);

    // held acknowledge, R9
    doCycle(1'b0, 1'b0, 24'h000050, 32'h0, 2'b11, 0, 32'h0, 12);
    tPrev = tRdy;
    doCycle(1'b0, 1'b0, 24'h000054, 32'h0, 2'b11, 0, 32'h77, 0);
    chk(tAsRise == tPrev + 12 + 7, "R9", "as after release", tAsRise - tPrev, 19);

    // locked pair, R10
    reqBase = reqRises; asBase = asRises;
    doCycle(1'b0, 1'b1, 24'h000060, 32'h0, 2'b11, 1, 32'h0000BEEF, 0);
    chk(addrStrobe && busGrantAck, "R10", "held after locked read", {addrStrobe, busGrantAck}, 2'b11);
    doCycle(1'b1, 1'b1, 24'h000060, 32'h0000BEF0, 2'b11, 1, 32'h0, 0);
    chk(asRises - asBase == 1, "R10", "as rises in pair", asRises - asBase, 1);
    chk(reqRises - reqBase == 1, "R10", "requests in pair", reqRises - reqBase, 1);
    chk(seenWdata == 32'h0000BEF0 && seenWrite, "R10", "pair write", seenWdata, 32'h0000BEF0);

    // locked read abandoned, R11
    doCycle(1'b0, 1'b1, 24'h000070, 32'h0, 2'b11, 0, 32'h0, 0);
    chk(addrStrobe && busGrantAck, "R11", "held before drop", {addrStrobe, busGrantAck}, 2'b11);
    @(negedge clk); dspLock = 1'b0;
    repeat (3) @(negedge clk);
    chk(!addrStrobe && !busGrantAck, "R11", "released after drop", {addrStrobe, busGrantAck}, 0);
    lockReadCur = 0;

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule